// File: doc/BRIEF.md
# Character Page Memory Access Controller

This block is the host-side access path of a character-cell display processor. It holds a cursor made of a row and a column, two 8-bit host holding registers (A and B), and two parallel 1K-byte page memories that share one address taken from the cursor. The host selects an action through a mode register. It then starts that action by writing a byte into holding register B. Depending on the mode, the action stores both holding registers into the page memories, or loads both registers from the page memories. It may then move the cursor on by one cell, wrapping at 40 columns and 24 rows.

There is also a slice-write mode that fills an external 1K-byte character-generator RAM. The block reads the character code stored in page B at the cursor. When that code lies in the user-definable range, the block forms a scrambled character-generator address from the code and the current slice number, and presents register A on a write port. The slice number then steps on modulo 10 while the cursor stays where it is. A busy flag is high for exactly the one clock in which an action runs. The cursor and mode values can be loaded by a separate command decoder, which the block models as simple load strobes.

Top module: `txt_mem_access`

## Requirements
- R1: After reset, curRow, curCol, mode, busy and cgWrEn are 0, and rdData reads 0 with either regSel value.
- R2: A wrEn with regSel=1 while busy is low loads wrData into register B and starts an action: busy is 1 in the next cycle only. Host writes to register A, mode loads and cursor loads that arrive while busy is high are dropped.
- R3: The page-memory address of an action is ((curRow << 5) | curCol) & 0x3FF.
- R4: With mode[7:5]=000, the action stores A and B at the cursor address into page memories A and B, then advances the cursor.
- R5: With mode[7:5]=001, the action loads A and B from page memories A and B at the cursor address, then advances the cursor.
- R6: Mode 010 stores like R4 and mode 011 loads like R5, and neither moves the cursor.
- R7: Advancing increments curCol. From column 39 it goes to column 0 with curRow+1, and row 23 wraps to row 0.
- R8: With mode[7:5]=100, the slice write reads byte b from page B at the cursor. If b >= 0xA0, cgWrEn is 1 in the busy cycle with cgData equal to register A. Otherwise cgWrEn stays 0. The cursor does not move.
- R9: The slice number s is mode[3:0] mod 10, and the code is c = b & 0x7F. For s < 8, cgAddr = {c, s[2:0]}. For s = 8 or 9, cgAddr = {2'b00, c[4:0], c[6:5], s[0]}.
- R10: After a slice write, mode[3:0] becomes (s+1) mod 10 and mode[7:4] is kept, whether or not the RAM was written.
- R11: mode[7:5] values 101, 110 and 111 access no memory, leave the cursor, mode and register A unchanged, and never raise cgWrEn.
- R12: rdData returns register B when regSel=1 and register A when regSel=0. Reading never raises busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Host register write strobe |
| regSel | input | 1 | Register select: 0 = A, 1 = B (write to B starts an action) |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Selected holding register contents |
| modeWr | input | 1 | Load strobe for the mode register |
| modeIn | input | 8 | New mode value |
| curLd | input | 1 | Load strobe for the cursor |
| curRowIn | input | 5 | New cursor row (0..23) |
| curColIn | input | 6 | New cursor column (0..39) |
| busy | output | 1 | High in the cycle an action executes |
| mode | output | 8 | Current mode register |
| curRow | output | 5 | Current cursor row |
| curCol | output | 6 | Current cursor column |
| cgWrEn | output | 1 | Character-generator RAM write enable |
| cgAddr | output | 10 | Character-generator RAM address |
| cgData | output | 8 | Character-generator RAM write data |

## Verification
The assertions check the timing rules on every cycle. They check that busy lasts exactly one cycle after a trigger, that cgWrEn appears only inside a slice-write busy cycle, that the cursor holds still for every non-advancing mode, and that the slice nibble steps modulo 10. The bench scenarios are needed for the data: what lands in the page memories and reads back, the scrambled character-generator addresses for slices 8 and 9, the 0xA0 threshold, and the column and row wrap at the screen's last cell. The bench does this by filling every cursor position and then running a seeded random mix of actions against its own model.

// File: rtl/txt_pkg.sv
package txt_pkg;
  localparam int DATA_W = 8;
  localparam int ROW_W  = 5;
  localparam int COL_W  = 6;
  localparam int ADDR_W = 10;

  typedef enum logic [2:0] {
    ACT_WR_ADV = 3'd0,
    ACT_RD_ADV = 3'd1,
    ACT_WR     = 3'd2,
    ACT_RD     = 3'd3,
    ACT_SLC_WR = 3'd4,
    ACT_SLC_RD = 3'd5
  } act_e;

  typedef struct packed {
    logic ldA;     // host write to register A
    logic ldMode;  // mode register load
    logic ldCur;   // cursor load
    logic trig;    // B written, page read issued
    logic memWr;   // store A/B into page memories
    logic regLd;   // load A/B from page read data
    logic adv;     // advance cursor
    logic slcWr;   // slice write step
  } strobe_t;
endpackage

// File: rtl/txt_ctrl.sv
module txt_ctrl
  import txt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       regSel,
  input  logic       modeWr,
  input  logic       curLd,
  input  logic [2:0] actSel,
  output logic       busy,
  output strobe_t    stb
);
  logic idle;
  assign idle = ~busy;

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= wrEn & regSel & idle;
  end

  always_comb begin
    stb        = '0;
    stb.ldA    = wrEn & ~regSel & idle;
    stb.trig   = wrEn & regSel & idle;
    stb.ldMode = modeWr & idle;
    stb.ldCur  = curLd & idle;
    if (busy) begin
      case (actSel)
        ACT_WR_ADV: begin stb.memWr = 1'b1; stb.adv = 1'b1; end
        ACT_RD_ADV: begin stb.regLd = 1'b1; stb.adv = 1'b1; end
        ACT_WR:     stb.memWr = 1'b1;
        ACT_RD:     stb.regLd = 1'b1;
        ACT_SLC_WR: stb.slcWr = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/txt_dpath.sv
module txt_dpath
  import txt_pkg::*;
#(
  parameter int COLS   = 40,
  parameter int ROWS   = 24,
  parameter int SLICES = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] modeIn,
  input  logic [ROW_W-1:0]  curRowIn,
  input  logic [COL_W-1:0]  curColIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] mode,
  output logic [ROW_W-1:0]  curRow,
  output logic [COL_W-1:0]  curCol,
  output logic              cgWrEn,
  output logic [ADDR_W-1:0] cgAddr,
  output logic [DATA_W-1:0] cgData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] USER_CODE_MIN = 8'hA0;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [3:0] LAST_SLICE = 4'(SLICES - 1);

  logic [DATA_W-1:0] pageA [DEPTH];
  logic [DATA_W-1:0] pageB [DEPTH];
  logic [DATA_W-1:0] regA, regB, rdA, rdB;
  logic [ADDR_W-1:0] pgAddr;
  logic [3:0]        slice, sliceNext;
  logic [6:0]        code;

  assign pgAddr = ADDR_W'({curRow, 5'b0}) | ADDR_W'(curCol);

  always_ff @(posedge clk) begin
    if (stb.trig) begin
      rdA <= pageA[pgAddr];
      rdB <= pageB[pgAddr];
    end
    if (stb.memWr) begin
      pageA[pgAddr] <= regA;
      pageB[pgAddr] <= regB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regA <= '0;
      regB <= '0;
    end else begin
      if (stb.ldA)  regA <= wrData;
      if (stb.trig) regB <= wrData;
      if (stb.regLd) begin
        regA <= rdA;
        regB <= rdB;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curRow <= '0;
      curCol <= '0;
    end else if (stb.ldCur) begin
      curRow <= curRowIn;
      curCol <= curColIn;
    end else if (stb.adv) begin
      if (curCol >= LAST_COL) begin
        curCol <= '0;
        curRow <= (curRow >= LAST_ROW) ? '0 : curRow + 1'b1;
      end else begin
        curCol <= curCol + 1'b1;
      end
    end
  end

  assign slice     = (mode[3:0] >= 4'(SLICES)) ? mode[3:0] - 4'(SLICES) : mode[3:0];
  assign sliceNext = (slice == LAST_SLICE) ? 4'd0 : slice + 4'd1;

  always_ff @(posedge clk) begin
    if (rst)             mode <= '0;
    else if (stb.ldMode) mode <= modeIn;
    else if (stb.slcWr)  mode <= {mode[7:4], sliceNext};
  end

  assign code   = rdB[6:0];
  assign cgAddr = slice[3] ? {2'b00, code[4:0], code[6:5], slice[0]}
                           : {code, slice[2:0]};
  assign cgWrEn = stb.slcWr & (rdB >= USER_CODE_MIN);
  assign cgData = regA;
  assign rdData = regSel ? regB : regA;
endmodule

// File: rtl/txt_mem_access.sv
module txt_mem_access
  import txt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic        regSel,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        modeWr,
  input  logic [7:0]  modeIn,
  input  logic        curLd,
  input  logic [4:0]  curRowIn,
  input  logic [5:0]  curColIn,
  output logic        busy,
  output logic [7:0]  mode,
  output logic [4:0]  curRow,
  output logic [5:0]  curCol,
  output logic        cgWrEn,
  output logic [9:0]  cgAddr,
  output logic [7:0]  cgData
);
  strobe_t stb;

  txt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .regSel(regSel),
    .modeWr(modeWr), .curLd(curLd), .actSel(mode[7:5]),
    .busy(busy), .stb(stb)
  );

  txt_dpath #(.COLS(40), .ROWS(24), .SLICES(10)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .regSel(regSel), .wrData(wrData),
    .modeIn(modeIn), .curRowIn(curRowIn), .curColIn(curColIn),
    .rdData(rdData), .mode(mode), .curRow(curRow), .curCol(curCol),
    .cgWrEn(cgWrEn), .cgAddr(cgAddr), .cgData(cgData)
  );
endmodule

// File: rtl/txt_mem_access_chk.sv
module txt_mem_access_chk (
  input logic       clk,
  input logic       rst,
  input logic       wrEn,
  input logic       regSel,
  input logic       busy,
  input logic [7:0] mode,
  input logic [4:0] curRow,
  input logic [5:0] curCol,
  input logic       cgWrEn
);
  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy); // R2

  AST_TRIG_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regSel && !busy) |=> busy); // R2

  AST_NOADV_HOLDS_CURSOR: assert property (@(posedge clk) disable iff (rst)
    (busy && mode[7:6] != 2'b00) |=> ($stable(curRow) && $stable(curCol))); // R6

  AST_CG_ONLY_SLICE: assert property (@(posedge clk) disable iff (rst)
    cgWrEn |-> (busy && mode[7:5] == 3'b100)); // R8

  AST_SLICE_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && mode[7:5] == 3'b100) |=>
      (mode[3:0] == ((4'($past(mode[3:0]) % 4'd10) == 4'd9) ? 4'd0
                     : 4'(4'($past(mode[3:0]) % 4'd10) + 4'd1))
       && mode[7:4] == $past(mode[7:4]))); // R10

  AST_IDLE_MODES_QUIET: assert property (@(posedge clk) disable iff (rst)
    (busy && mode[7:5] >= 3'b101) |=> $stable(mode)); // R11
endmodule

bind txt_mem_access txt_mem_access_chk u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .regSel(regSel), .busy(busy),
  .mode(mode), .curRow(curRow), .curCol(curCol), .cgWrEn(cgWrEn)
);

// File: tb/txt_mem_access_tb.sv
module txt_mem_access_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0, regSel = 1'b0, modeWr = 1'b0, curLd = 1'b0;
  logic [7:0] wrData = '0, modeIn = '0;
  logic [4:0] curRowIn = '0;
  logic [5:0] curColIn = '0;
  logic [7:0] rdData, mode, cgData;
  logic       busy, cgWrEn;
  logic [4:0] curRow;
  logic [5:0] curCol;
  logic [9:0] cgAddr;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  logic [7:0] mA [1024];
  logic [7:0] mB [1024];
  logic [7:0] tA = 0, tB = 0, tMode = 0;
  int tRow = 0, tCol = 0;

  always #10 clk = ~clk;

  txt_mem_access u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pgAddr(input int r, input int c);
    return ((r << 5) | c) & 32'h3ff;
  endfunction

  function automatic int cgAddrOf(input int b, input int s);
    int c = b & 32'h7f;
    if (s >= 8) return ((c & 32'h1f) << 3) | (((c >> 5) & 3) << 1) | (s & 1);
    return (c << 3) | (s & 7);
  endfunction

  task automatic writeA(input logic [7:0] d);
    @(negedge clk); wrEn = 1; regSel = 0; wrData = d;
    @(negedge clk); wrEn = 0;
    tA = d;
  endtask

  task automatic setMode(input logic [7:0] m);
    @(negedge clk); modeWr = 1; modeIn = m;
    @(negedge clk); modeWr = 0;
    tMode = m;
  endtask

  task automatic loadCur(input int r, input int c);
    @(negedge clk); curLd = 1; curRowIn = 5'(r); curColIn = 6'(c);
    @(negedge clk); curLd = 0;
    tRow = r; tCol = c;
  endtask

  task automatic readRegs(input string req);
    regSel = 0; #1;
    check(rdData == tA, req, rdData, tA);
    check(busy == 0, "R12 busy on read", busy, 0);
    regSel = 1; #1;
    check(rdData == tB, req, rdData, tB);
  endtask

  task automatic trigger(input logic [7:0] d);
    int a = pgAddr(tRow, tCol);
    int act = tMode[7:5];
    int s = tMode[3:0] % 10;
    bit expCg;
    @(negedge clk); wrEn = 1; regSel = 1; wrData = d;
    @(negedge clk); wrEn = 0;
    tB = d;
    check(busy == 1, "R2 busy during action", busy, 1);
    expCg = (act == 4) && (mB[a] >= 8'hA0);
    check(cgWrEn == expCg, act == 4 ? "R8 cgWrEn" : "R11 cgWrEn", cgWrEn, expCg);
    if (expCg) begin
      check(cgAddr == 10'(cgAddrOf(mB[a], s)), "R9 cgAddr", cgAddr, cgAddrOf(mB[a], s));
      check(cgData == tA, "R8 cgData", cgData, tA);
    end
    case (act)
      0, 2: begin mA[a] = tA; mB[a] = tB; end
      1, 3: begin tA = mA[a]; tB = mB[a]; end
      4: tMode = {tMode[7:4], 4'((s + 1) % 10)};
      default: ;
    endcase
    if (act == 0 || act == 1) begin
      tCol++;
      if (tCol >= 40) begin tCol = 0; tRow = (tRow + 1) % 24; end
    end
    @(negedge clk);
    check(busy == 0, "R2 busy one cycle", busy, 0);
    check(curRow == 5'(tRow) && curCol == 6'(tCol),
          act <= 1 ? "R7 cursor advance" : "R6 cursor held", {curRow, curCol}, (tRow << 6) | tCol);
    check(mode == tMode, act == 4 ? "R10 slice step" : "R11 mode kept", mode, tMode);
    readRegs(act == 1 || act == 3 ? "R5 read data" : "R4 register");
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int unused = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(curRow == 0 && curCol == 0, "R1 cursor", {curRow, curCol}, 0);
    check(mode == 0 && busy == 0 && cgWrEn == 0, "R1 mode/busy", {mode, busy, cgWrEn}, 0);
    regSel = 0; #1; check(rdData == 0, "R1 regA", rdData, 0);
    regSel = 1; #1; check(rdData == 0, "R1 regB", rdData, 0);

    // R3/R6: fill every cursor cell with write-no-advance
    setMode(8'h40);
    for (int r = 0; r < 24; r++)
      for (int c = 0; c < 40; c++) begin
        loadCur(r, c);
        writeA(8'($urandom));
        trigger(8'($urandom));
      end

    // R3 aliasing: column >= 32 overlaps row bit; read back through model
    setMode(8'h60); loadCur(1, 33); trigger(8'h00);
    loadCur(0, 33); trigger(8'h00);

    // R7 wrap corners
    setMode(8'h00); loadCur(23, 39); writeA(8'h11); trigger(8'h22);
    check(curRow == 0 && curCol == 0, "R7 wrap to origin", {curRow, curCol}, 0);
    loadCur(5, 39); trigger(8'h33);
    check(curRow == 6 && curCol == 0, "R7 row step", {curRow, curCol}, 6 << 6);
    setMode(8'h20); loadCur(23, 39); trigger(8'h00);
    check(rdData == 8'h22, "R5 read back B", rdData, 8'h22);

    // R8/R9 slice writes: user codes and a low code
    setMode(8'h40); loadCur(2, 2); writeA(8'h00); trigger(8'hD5);
    loadCur(2, 3); trigger(8'h9F);
    loadCur(2, 2);
    for (int k = 0; k < 12; k++) begin
      setMode(8'h80 | 8'(k == 11 ? 15 : (k % 10)));
      writeA(8'($urandom));
      trigger(8'h5A);
    end
    loadCur(2, 3); setMode(8'h88); trigger(8'h00);
    check(cgWrEn == 0, "R8 low code no write", cgWrEn, 0);

    // R11 quiet modes, then read back the cell
    loadCur(4, 4);
    for (int m = 5; m < 8; m++) begin
      setMode(8'(m << 5)); writeA(8'h77); trigger(8'hEE);
      setMode(8'h60); trigger(8'h00);
    end

    // R2 host writes while busy are dropped
    setMode(8'h60); writeA(8'h3C);
    @(negedge clk); wrEn = 1; regSel = 1; wrData = 8'h00;
    @(negedge clk); regSel = 0; wrData = 8'hC3; modeWr = 1; modeIn = 8'hFF;
    @(negedge clk); wrEn = 0; modeWr = 0;
    tA = mA[pgAddr(tRow, tCol)];
    regSel = 0; #1; check(rdData == tA, "R2 A write dropped", rdData, tA);
    check(mode == 8'h60, "R2 mode load dropped", mode, 8'h60);
    tB = mB[pgAddr(tRow, tCol)];

    // random mix
    for (int i = 0; i < 400; i++) begin
      int p = $urandom_range(0, 9);
      if (p == 0) loadCur($urandom_range(0, 23), $urandom_range(0, 39));
      if (p == 1) writeA(8'($urandom));
      if (p <= 3) setMode({3'($urandom_range(0, 7)), 1'b0, 4'($urandom)});
      trigger(8'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule